// File: doc/BRIEF.md
# Dual-Standard RGB to YCbCr Pixel Converter

This block turns a stream of RGB pixels, one 8-bit sample per colour, into YCbCr 4:4:4 pixels with 10-bit components in studio range. Each output pixel depends only on its own input pixel. The block needs no frame width or height, and it has no control packets. Start-of-frame and end-of-line flags travel with each pixel and come out aligned with the converted data.

Two coefficient matrices are built in: one for high-definition material and one for standard-definition material. A single input picks the matrix at run time, so one instance can handle both video formats. That input takes effect only at the start of a frame, so every frame is converted with one set of coefficients. The datapath has three register stages and uses a valid/ready handshake. When the downstream side is not ready, the whole pipeline stalls.

The coefficient constants are fixed-point values with 12 fractional bits. They are scaled for 8-bit inputs and 10-bit outputs, so the width parameters keep those defaults.

Top module: `rgb2ycc_dual`

## Requirements
- R1: During and right after a synchronous active-high reset, `out_valid` is 0. With `out_ready` high, `in_ready` is 1.
- R2: Luma is computed as `out_y = clamp(64 + ((S + 2048) >>> 12))`, where `S = cr*R + cg*G + cb*B`. The shift is arithmetic, so the result rounds half up. The HD set is (cr, cg, cb) = (2991, 10064, 1016). The SD set is (4207, 8260, 1604).
- R3: Blue-difference chroma uses the same form with offset 512. The HD set is (-1649, -5547, 7196). The SD set is (-2428, -4768, 7196).
- R4: Red-difference chroma uses the same form with offset 512. The HD set is (7196, -6536, -660). The SD set is (7196, -6026, -1170).
- R5: `std_hd` = 1 selects the HD set and `std_hd` = 0 selects the SD set. A grey input (R = G = B) gives chroma of exactly 512 in both sets.
- R6: The standard is captured only when a pixel with `in_sof` = 1 is accepted. That pixel and all later pixels use the value `std_hd` has at the accepting clock edge. Changes to `std_hd` at other times have no effect. Pixels accepted after reset but before the first start-of-frame use the SD set.
- R7: A pixel passes through three register stages. With `out_ready` held high, a pixel accepted at clock edge n is presented on the outputs after edge n+2. Its `sof` and `eol` flags arrive with it.
- R8: While `out_valid` = 1 and `out_ready` = 0, `in_ready` is 0 and all outputs hold their values. No pixel is lost or repeated.
- R9: Luma stays within 64..940 and both chroma outputs stay within 64..960.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block accepts a pixel this cycle |
| in_r | input | 8 | Red sample |
| in_g | input | 8 | Green sample |
| in_b | input | 8 | Blue sample |
| in_sof | input | 1 | Pixel starts a frame |
| in_eol | input | 1 | Pixel ends a line |
| std_hd | input | 1 | 1 = HD matrix, 0 = SD matrix (taken at start of frame) |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Downstream accepts the output pixel |
| out_y | output | 10 | Luma |
| out_cb | output | 10 | Blue-difference chroma |
| out_cr | output | 10 | Red-difference chroma |
| out_sof | output | 1 | Start-of-frame flag, aligned to the data |
| out_eol | output | 1 | End-of-line flag, aligned to the data |

## Verification
The capture of the standard and the backpressure stall can happen in the same cycle. This occurs when a start-of-frame pixel is waiting at a stalled input while `std_hd` changes underneath it. The bench fills the pipeline with `out_ready` held low and presents a start-of-frame pixel. It flips `std_hd` during the stall, then releases the stall. The pixel must be converted with the value in force at the accepting edge, and nothing from the stall may change the pixels already in flight. Separately, a sweep over a 16-level grid per colour in both standards, run under pseudo-random backpressure, is compared against the integer formulas.

// File: rtl/ycc_pkg.sv
package ycc_pkg;
  localparam int CF_W = 16;
  localparam int FRAC = 12;
  localparam int NCOMP = 3;

  typedef logic signed [CF_W-1:0] coef_t;
  typedef enum logic {STD_SD = 1'b0, STD_HD = 1'b1} std_e;

  // row: 0 luma, 1 blue diff, 2 red diff; col: 0 red, 1 green, 2 blue
  function automatic coef_t coef(input std_e s, input int row, input int col);
    int idx;
    idx = row * 3 + col;
    if (s == STD_HD) begin
      case (idx)
        0: return 16'sd2991;  1: return 16'sd10064; 2: return 16'sd1016;
        3: return -16'sd1649; 4: return -16'sd5547; 5: return 16'sd7196;
        6: return 16'sd7196;  7: return -16'sd6536; default: return -16'sd660;
      endcase
    end else begin
      case (idx)
        0: return 16'sd4207;  1: return 16'sd8260;  2: return 16'sd1604;
        3: return -16'sd2428; 4: return -16'sd4768; 5: return 16'sd7196;
        6: return 16'sd7196;  7: return -16'sd6026; default: return -16'sd1170;
      endcase
    end
  endfunction

  function automatic int row_ofs(input int row, input int out_w);
    return (row == 0) ? (16 << (out_w - 8)) : (128 << (out_w - 8));
  endfunction

  function automatic int row_lo(input int out_w);
    return 16 << (out_w - 8);
  endfunction

  function automatic int row_hi(input int row, input int out_w);
    return (row == 0) ? (235 << (out_w - 8)) : (240 << (out_w - 8));
  endfunction
endpackage

// File: rtl/ycc_std_hold.sv
module ycc_std_hold
  import ycc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic take,      // a pixel is accepted this cycle
  input  logic take_sof,  // that pixel starts a frame
  input  logic std_in,
  output std_e std_eff
);
  std_e held_q;

  // a frame-start pixel already uses the new standard
  always_comb begin
    std_eff = (take && take_sof) ? std_e'(std_in) : held_q;
  end

  always_ff @(posedge clk) begin
    if (rst)
      held_q <= STD_SD;
    else if (take && take_sof)
      held_q <= std_e'(std_in);
  end
endmodule

// File: rtl/ycc_row.sv
module ycc_row
  import ycc_pkg::*;
#(
  parameter int IN_W  = 8,
  parameter int OUT_W = 10,
  parameter int ROW   = 0
) (
  input  logic             clk,
  input  logic             adv,
  input  std_e             std_sel,
  input  logic [IN_W-1:0]  px [NCOMP],
  output logic [OUT_W-1:0] res
);
  localparam int PROD_W = CF_W + IN_W + 1;
  localparam int SUM_W  = PROD_W + 2;
  localparam int OFS    = row_ofs(ROW, OUT_W);
  localparam int LO     = row_lo(OUT_W);
  localparam int HI     = row_hi(ROW, OUT_W);
  localparam logic signed [SUM_W-1:0] HALF = SUM_W'(1) <<< (FRAC - 1);

  logic signed [PROD_W-1:0] prod_q [NCOMP];
  logic signed [SUM_W-1:0]  acc_q;

  // stage 1: one product per colour
  for (genvar k = 0; k < NCOMP; k++) begin : g_mul
    logic signed [PROD_W-1:0] cf_x;
    logic signed [PROD_W-1:0] px_x;
    coef_t cf;
    always_comb begin
      cf   = coef(std_sel, ROW, k);
      cf_x = {{(PROD_W-CF_W){cf[CF_W-1]}}, cf};
      px_x = {{(PROD_W-IN_W){1'b0}}, px[k]};
    end
    always_ff @(posedge clk) begin
      if (adv) prod_q[k] <= cf_x * px_x;
    end
  end

  // stage 2: sum, round half up, add offset
  logic signed [SUM_W-1:0] sum_c;
  always_comb begin
    sum_c = '0;
    for (int k = 0; k < NCOMP; k++)
      sum_c = sum_c + {{(SUM_W-PROD_W){prod_q[k][PROD_W-1]}}, prod_q[k]};
  end

  always_ff @(posedge clk) begin
    if (adv) acc_q <= SUM_W'(OFS) + ((sum_c + HALF) >>> FRAC);
  end

  // stage 3: clamp to the legal range and register
  always_ff @(posedge clk) begin
    if (adv) begin
      if (acc_q < SUM_W'(LO))
        res <= OUT_W'(LO);
      else if (acc_q > SUM_W'(HI))
        res <= OUT_W'(HI);
      else
        res <= acc_q[OUT_W-1:0];
    end
  end
endmodule

// File: rtl/rgb2ycc_dual.sv
module rgb2ycc_dual
  import ycc_pkg::*;
#(
  parameter int IN_W   = 8,
  parameter int OUT_W  = 10,
  parameter int STAGES = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_r,
  input  logic [IN_W-1:0]  in_g,
  input  logic [IN_W-1:0]  in_b,
  input  logic             in_sof,
  input  logic             in_eol,
  input  logic             std_hd,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_y,
  output logic [OUT_W-1:0] out_cb,
  output logic [OUT_W-1:0] out_cr,
  output logic             out_sof,
  output logic             out_eol
);
  localparam int LAST = STAGES - 1;

  logic adv;
  logic vld_q [STAGES];
  logic sof_q [STAGES];
  logic eol_q [STAGES];
  std_e std_now;
  logic [IN_W-1:0]  px [NCOMP];
  logic [OUT_W-1:0] res [NCOMP];

  // whole pipe moves unless the last stage holds an unaccepted pixel
  assign adv      = !vld_q[LAST] || out_ready;
  assign in_ready = adv;

  assign px[0] = in_r;
  assign px[1] = in_g;
  assign px[2] = in_b;

  ycc_std_hold u_std (
    .clk      (clk),
    .rst      (rst),
    .take     (in_valid && adv),
    .take_sof (in_sof),
    .std_in   (std_hd),
    .std_eff  (std_now)
  );

  for (genvar r = 0; r < NCOMP; r++) begin : g_row
    ycc_row #(.IN_W(IN_W), .OUT_W(OUT_W), .ROW(r)) u_row (
      .clk     (clk),
      .adv     (adv),
      .std_sel (std_now),
      .px      (px),
      .res     (res[r])
    );
  end

  // sideband delay line matched to the datapath
  for (genvar s = 0; s < STAGES; s++) begin : g_side
    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q[s] <= 1'b0;
        sof_q[s] <= 1'b0;
        eol_q[s] <= 1'b0;
      end else if (adv) begin
        if (s == 0) begin
          vld_q[s] <= in_valid;
          sof_q[s] <= in_sof;
          eol_q[s] <= in_eol;
        end else begin
          vld_q[s] <= vld_q[(s == 0) ? 0 : s-1];
          sof_q[s] <= sof_q[(s == 0) ? 0 : s-1];
          eol_q[s] <= eol_q[(s == 0) ? 0 : s-1];
        end
      end
    end
  end

  assign out_valid = vld_q[LAST];
  assign out_sof   = sof_q[LAST];
  assign out_eol   = eol_q[LAST];
  assign out_y     = res[0];
  assign out_cb    = res[1];
  assign out_cr    = res[2];
endmodule

// File: rtl/ycc_chk.sv
module ycc_chk #(
  parameter int OUT_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_y,
  input logic [OUT_W-1:0] out_cb,
  input logic [OUT_W-1:0] out_cr,
  input logic             out_sof,
  input logic             out_eol
);
  localparam int LO   = 16 << (OUT_W - 8);
  localparam int Y_HI = 235 << (OUT_W - 8);
  localparam int C_HI = 240 << (OUT_W - 8);

  AST_RST_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid); // R1

  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready); // R8

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_y) && $stable(out_cb)
      && $stable(out_cr) && $stable(out_sof) && $stable(out_eol))); // R8

  AST_Y_LEGAL: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (int'(out_y) >= LO && int'(out_y) <= Y_HI)); // R9

  AST_C_LEGAL: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (int'(out_cb) >= LO && int'(out_cb) <= C_HI
                && int'(out_cr) >= LO && int'(out_cr) <= C_HI)); // R9
endmodule

bind rgb2ycc_dual ycc_chk #(.OUT_W(OUT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_y     (out_y),
  .out_cb    (out_cb),
  .out_cr    (out_cr),
  .out_sof   (out_sof),
  .out_eol   (out_eol)
);

// File: tb/tb_rgb2ycc_dual.sv
module tb_rgb2ycc_dual;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eol = 1'b0, std_hd = 1'b0;
  logic [7:0] in_r = '0, in_g = '0, in_b = '0;
  logic in_ready, out_valid, out_sof, out_eol;
  logic out_ready = 1'b1;
  logic [9:0] out_y, out_cb, out_cr;

  always #2.5 clk = ~clk;

  rgb2ycc_dual dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_r(in_r), .in_g(in_g), .in_b(in_b), .in_sof(in_sof), .in_eol(in_eol),
    .std_hd(std_hd), .out_valid(out_valid), .out_ready(out_ready),
    .out_y(out_y), .out_cb(out_cb), .out_cr(out_cr),
    .out_sof(out_sof), .out_eol(out_eol)
  );

  int n_chk = 0;
  int n_fail = 0;
  string tag = "R2";
  logic [31:0] expq [$];
  bit hd_model = 1'b0;
  bit hold_ready = 1'b0;
  bit bp_on = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string req, input int got, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  // integer model written from the R2..R4 formulas
  function automatic int model(input bit hd, input int row, input int r, input int g, input int b);
    int c0, c1, c2, s, v, hi;
    case ({hd, 2'(row)})
      3'b100: begin c0 = 2991;  c1 = 10064; c2 = 1016;  end
      3'b101: begin c0 = -1649; c1 = -5547; c2 = 7196;  end
      3'b110: begin c0 = 7196;  c1 = -6536; c2 = -660;  end
      3'b000: begin c0 = 4207;  c1 = 8260;  c2 = 1604;  end
      3'b001: begin c0 = -2428; c1 = -4768; c2 = 7196;  end
      default: begin c0 = 7196; c1 = -6026; c2 = -1170; end
    endcase
    s  = c0 * r + c1 * g + c2 * b;
    v  = ((row == 0) ? 64 : 512) + ((s + 2048) >>> 12);
    hi = (row == 0) ? 940 : 960;
    if (v < 64) v = 64;
    if (v > hi) v = hi;
    return v;
  endfunction

  // present one pixel; if stalled, std_hd switches to alt while waiting
  task automatic send(input int r, input int g, input int b, input bit sof,
                      input bit eol, input bit mode, input bit alt);
    bit taken;
    @(negedge clk);
    in_valid = 1'b1; in_r = 8'(r); in_g = 8'(g); in_b = 8'(b);
    in_sof = sof; in_eol = eol; std_hd = mode;
    taken = 1'b0;
    while (!taken) begin
      #2;
      if (in_ready) taken = 1'b1;
      else begin
        @(negedge clk);
        std_hd = alt;
      end
    end
    if (sof) hd_model = std_hd;
    expq.push_back({model(hd_model, 0, r, g, b)[9:0], model(hd_model, 1, r, g, b)[9:0],
                    model(hd_model, 2, r, g, b)[9:0], sof, eol});
    @(posedge clk);
    #0.5 in_valid = 1'b0;
  endtask

  // output side: drive ready, score accepted pixels, check stalls
  bit was_stall = 1'b0;
  logic [31:0] stall_snap;
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = hold_ready ? 1'b0 : (bp_on ? lfsr[0] : 1'b1);
    #1;
    if (!rst) begin
      if (was_stall) begin
        // R8: held pixel unchanged after a stalled edge
        check(out_valid && {out_y, out_cb, out_cr, out_sof, out_eol} == stall_snap,
              "R8 hold", int'(out_y), int'(stall_snap[31:22]));
      end
      was_stall = out_valid && !out_ready;
      stall_snap = {out_y, out_cb, out_cr, out_sof, out_eol};
      if (out_valid && !out_ready) check(!in_ready, "R8 in_ready", int'(in_ready), 0);
      if (out_valid && out_ready) begin
        if (expq.size() == 0) check(1'b0, "R8 extra pixel", 1, 0);
        else begin
          logic [31:0] e;
          e = expq.pop_front();
          check(out_y == e[31:22], {tag, "/R2 luma"}, int'(out_y), int'(e[31:22]));
          check(out_cb == e[21:12], {tag, "/R3 cb"}, int'(out_cb), int'(e[21:12]));
          check(out_cr == e[11:2], {tag, "/R4 cr"}, int'(out_cr), int'(e[11:2]));
          check({out_sof, out_eol} == e[1:0], {tag, "/R7 flags"},
                int'({out_sof, out_eol}), int'(e[1:0]));
        end
      end
    end
  end

  task automatic drain();
    int guard = 0;
    while (expq.size() != 0 && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    #3;
    check(expq.size() == 0, "R8 pixels lost", expq.size(), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired got 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    repeat (4) @(posedge clk);
    #0.5;
    check(!out_valid, "R1 out_valid", int'(out_valid), 0);
    rst = 1'b0;
    @(negedge clk); #2;
    check(!out_valid && in_ready, "R1 idle", int'({out_valid, in_ready}), 1);

    // R6: no frame start yet, HD request must be ignored (SD used)
    tag = "R6";
    send(200, 30, 90, 1'b0, 1'b0, 1'b1, 1'b1);
    send(10, 250, 40, 1'b0, 1'b1, 1'b1, 1'b1);
    drain();

    // R7: latency with ready high
    tag = "R7";
    @(negedge clk);
    in_valid = 1'b1; in_r = 8'd128; in_g = 8'd128; in_b = 8'd128;
    in_sof = 1'b1; in_eol = 1'b1; std_hd = 1'b1;
    #2;
    hd_model = 1'b1;
    expq.push_back({10'(model(1, 0, 128, 128, 128)), 10'd512, 10'd512, 1'b1, 1'b1});
    @(posedge clk); #0.5 in_valid = 1'b0;
    @(negedge clk); #2 check(!out_valid, "R7 edge n", int'(out_valid), 0);
    @(negedge clk); #2 check(!out_valid, "R7 edge n+1", int'(out_valid), 0);
    @(negedge clk); #2 check(out_valid && out_sof && out_eol, "R7 edge n+2",
                             int'({out_valid, out_sof, out_eol}), 7);
    drain();

    // R5: grey gives centred chroma in SD as well
    tag = "R5";
    send(77, 77, 77, 1'b1, 1'b0, 1'b0, 1'b0);
    send(255, 255, 255, 1'b0, 1'b0, 1'b0, 1'b0);
    send(0, 0, 0, 1'b0, 1'b1, 1'b0, 1'b0);
    drain();

    // R6: mid-frame change ignored
    tag = "R6";
    send(255, 0, 0, 1'b1, 1'b0, 1'b1, 1'b1);
    send(0, 255, 0, 1'b0, 1'b0, 1'b0, 1'b0);
    send(0, 0, 255, 1'b0, 1'b1, 1'b0, 1'b0);
    drain();

    // R6 with R8: frame start stalled while std_hd flips
    tag = "R6";
    hold_ready = 1'b1;
    send(20, 40, 60, 1'b0, 1'b0, 1'b0, 1'b0);
    send(220, 10, 130, 1'b0, 1'b0, 1'b0, 1'b0);
    send(90, 180, 30, 1'b0, 1'b1, 1'b0, 1'b0);
    fork
      send(255, 128, 0, 1'b1, 1'b0, 1'b1, 1'b0);
      begin
        repeat (5) @(posedge clk);
        #0.5 hold_ready = 1'b0;
      end
    join
    send(0, 128, 255, 1'b0, 1'b1, 1'b1, 1'b1);
    drain();

    // R2/R3/R4/R5 sweep in both standards under backpressure
    bp_on = 1'b1;
    for (int m = 0; m < 2; m++) begin
      tag = (m == 1) ? "R5 hd" : "R5 sd";
      for (int i = 0; i < 4096; i++) begin
        send((i % 16) * 17, ((i / 16) % 16) * 17, (i / 256) * 17,
             i == 0, (i % 64) == 63, 1'(m), 1'(m));
      end
      drain();
    end
    bp_on = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule